// File: doc/BRIEF.md
# Grouped Interrupt Combiner

This block collects a wide bank of level-sensitive interrupt sources and folds them into groups of eight. Each group has an 8-bit enable mask. Each group drives one request line, which is high while any enabled source of that group is high. Source `n` belongs to group `n/8` at bit position `n%8`. A parameter picks either the full instance with 64 active groups (512 sources) or a reduced instance in which only groups 0 to 15 react to their inputs.

Software reaches the block through a plain register port. The port has a word address, a write strobe with data, and a read strobe with registered read data. The address space is split into quads of four 32-bit words. Quad `q` covers groups `4q` to `4q+3`, and each group takes one byte lane. Within a quad, one word sets enable bits and one word clears them. A third word returns the raw source levels and a fourth returns those levels after masking. Two summary words after the quads show which group lines are currently high.

The port carries a word address, equal to the byte offset divided by four. Byte offset `0x100` is word address 64, `0x104` is 65, and the decoded window ends at byte `0x108`.

Top module: `irq_combiner`

## Requirements
- R1: Source input `n` is bit `n%8` of group `n/8`, and group `g` drives request output bit `g`.
- R2: A group request is high exactly when (enable mask AND pending bits) of that group is nonzero. The request is registered and reflects an input or enable change at the next rising clock edge.
- R3: A pending bit follows its input level. Word 2 of quad `q` (word address `4q+2`) reads the pending bits of group `4q+k` in bits `8k+7:8k`.
- R4: Quad `q` sits at byte offset `16q` (word address `4q`). Group `4q+k` uses byte lane `k`, bits `8k+7:8k`, in every word of the quad.
- R5: A write to word 0 of a quad (word address `4q`) sets each enable bit whose data bit is 1 and leaves bits written 0 unchanged. The new mask takes effect on the write's clock edge.
- R6: A write to word 1 of a quad (word address `4q+1`) clears each enable bit whose data bit is 1 and leaves bits written 0 unchanged.
- R7: Word 3 of a quad (word address `4q+3`) reads the pending bits ANDed with the enable mask, in the same lane layout.
- R8: Summary word address 64 (byte `0x100`) has bit `g` set while request `g` is high, for `g<32`. Word address 65 (byte `0x104`) holds group `g` in bit `g-32`.
- R9: Writes to status words, to the summary words or beyond them change nothing. Reads of words 0 and 1 of a quad, and of any word address of 66 or more, return zero.
- R10: In the reduced variant, inputs of groups 16 and above have no effect: those requests stay low and their status lanes read zero.
- R11: Reset clears every enable mask, every pending bit, every request and both summary words.
- R12: Read data is registered. It changes only on a clock edge where the read strobe is high, and then holds the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 512 | Level-sensitive interrupt sources |
| waddr | input | 7 | Word address (byte offset / 4) |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| grp_irq | output | 64 | Per-group combined request |

## Verification
The assertions assume that the inputs are synchronous to `clk` and that no input is X after reset. They also assume that a single access names one word, so a set and a clear can never reach the same group in one cycle. The bench drives every input on the falling edge and issues each write or read as a one-cycle strobe. It changes source levels only between accesses and never drives X. This keeps the stimulus inside those assumptions, and each rising edge sees one settled request.

// File: rtl/comb_pkg.sv
package comb_pkg;
   localparam int SRC_PER_GRP   = 8;
   localparam int GRPS_PER_QUAD = 4;

   typedef enum logic [1:0] {
      W_EN_SET = 2'd0,
      W_EN_CLR = 2'd1,
      W_RAW    = 2'd2,
      W_MASKED = 2'd3
   } quad_word_e;
endpackage

// File: rtl/comb_group.sv
module comb_group #(
   parameter int SRC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] src_lvl,
   input  logic [SRC_W-1:0] set_bits,
   input  logic [SRC_W-1:0] clr_bits,
   output logic [SRC_W-1:0] en_mask,
   output logic [SRC_W-1:0] pend,
   output logic             grp_req
);
   logic [SRC_W-1:0] mask_nxt;

   assign mask_nxt = (en_mask | set_bits) & ~clr_bits;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_mask <= '0;
         pend    <= '0;
         grp_req <= 1'b0;
      end else begin
         en_mask <= mask_nxt;
         pend    <= src_lvl;
         grp_req <= |(mask_nxt & src_lvl);
      end
   end

   assert_set_bits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (|set_bits) |=> ((en_mask & $past(set_bits)) == $past(set_bits)));

   assert_clr_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_bits) |=> ((en_mask & $past(clr_bits)) == '0));

   assert_mask_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (set_bits == '0 && clr_bits == '0) |=> $stable(en_mask));

   assert_req_consistent_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (grp_req == |(en_mask & pend)));
endmodule

// File: rtl/comb_regif.sv
module comb_regif
   import comb_pkg::*;
#(
   parameter int NUM_GRP = 64,
   parameter int SRC_W   = 8,
   parameter int DATA_W  = 32,
   parameter int WA_W    = 7
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [WA_W-1:0]          waddr,
   input  logic                     wr_en,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic                     rd_en,
   input  logic [NUM_GRP*SRC_W-1:0] pend_all,
   input  logic [NUM_GRP*SRC_W-1:0] mask_all,
   input  logic [NUM_GRP-1:0]       grp_req,
   output logic [NUM_GRP*SRC_W-1:0] set_all,
   output logic [NUM_GRP*SRC_W-1:0] clr_all,
   output logic [DATA_W-1:0]        rd_data
);
   localparam int QUADS = NUM_GRP / GRPS_PER_QUAD;
   localparam int QW    = $clog2(QUADS);

   if (SRC_W * GRPS_PER_QUAD != DATA_W) begin : g_chk_lane
      $error("comb_regif: four byte lanes must fill one data word");
   end
   if (NUM_GRP != 2 * DATA_W) begin : g_chk_sum
      $error("comb_regif: summary must be exactly two words");
   end
   if (WA_W != QW + 3) begin : g_chk_addr
      $error("comb_regif: word address width does not match quad count");
   end

   logic             is_sum;
   logic [QW-1:0]    quad_idx;
   quad_word_e       wsel;
   logic [DATA_W-1:0] rd_word;

   assign is_sum   = waddr[WA_W-1];
   assign quad_idx = waddr[QW+1:2];
   assign wsel     = quad_word_e'(waddr[1:0]);

   for (genvar q = 0; q < QUADS; q++) begin : g_quad
      logic hit;
      assign hit = wr_en && !is_sum && (quad_idx == QW'(q));
      assign set_all[q*DATA_W +: DATA_W] = (hit && wsel == W_EN_SET) ? wr_data : '0;
      assign clr_all[q*DATA_W +: DATA_W] = (hit && wsel == W_EN_CLR) ? wr_data : '0;
   end

   always_comb begin
      rd_word = '0;
      if (is_sum) begin
         if (waddr[WA_W-2:1] == '0)
            rd_word = grp_req[waddr[0]*DATA_W +: DATA_W];
      end else begin
         case (wsel)
            W_RAW:    rd_word = pend_all[quad_idx*DATA_W +: DATA_W];
            W_MASKED: rd_word = pend_all[quad_idx*DATA_W +: DATA_W]
                              & mask_all[quad_idx*DATA_W +: DATA_W];
            default:  rd_word = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_word;
   end

   assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   assert_set_clr_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({|set_all, |clr_all}));

   assert_status_wr_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (is_sum || wsel == W_RAW || wsel == W_MASKED))
         |-> (set_all == '0 && clr_all == '0));
endmodule

// File: rtl/irq_combiner.sv
module irq_combiner #(
   parameter int SRC_PER_GRP = 8,
   parameter int MAP_GROUPS  = 64,
   parameter int DATA_W      = 32,
   parameter int WADDR_W     = 7,
   parameter bit REDUCED     = 1'b0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [MAP_GROUPS*SRC_PER_GRP-1:0] irq_in,
   input  logic [WADDR_W-1:0]                waddr,
   input  logic                              wr_en,
   input  logic [DATA_W-1:0]                 wr_data,
   input  logic                              rd_en,
   output logic [DATA_W-1:0]                 rd_data,
   output logic [MAP_GROUPS-1:0]             grp_irq
);
   localparam int ACTIVE = REDUCED ? 16 : MAP_GROUPS;
   localparam int NSRC   = MAP_GROUPS * SRC_PER_GRP;

   if (SRC_PER_GRP != comb_pkg::SRC_PER_GRP) begin : g_chk_src
      $error("irq_combiner: group width must match the package");
   end
   if (ACTIVE > MAP_GROUPS || ACTIVE % comb_pkg::GRPS_PER_QUAD != 0) begin : g_chk_act
      $error("irq_combiner: active group count invalid");
   end

   logic [NSRC-1:0]       pend_all, mask_all, set_all, clr_all;
   logic [MAP_GROUPS-1:0] grp_req;

   for (genvar g = 0; g < MAP_GROUPS; g++) begin : g_grp
      if (g < ACTIVE) begin : g_live
         comb_group #(.SRC_W(SRC_PER_GRP)) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .src_lvl  (irq_in [g*SRC_PER_GRP +: SRC_PER_GRP]),
            .set_bits (set_all[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .clr_bits (clr_all[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .en_mask  (mask_all[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .pend     (pend_all[g*SRC_PER_GRP +: SRC_PER_GRP]),
            .grp_req  (grp_req[g])
         );
      end else begin : g_dead
         assign mask_all[g*SRC_PER_GRP +: SRC_PER_GRP] = '0;
         assign pend_all[g*SRC_PER_GRP +: SRC_PER_GRP] = '0;
         assign grp_req[g] = 1'b0;

         assert_dead_group_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !grp_irq[g]);
      end
   end

   comb_regif #(
      .NUM_GRP (MAP_GROUPS),
      .SRC_W   (SRC_PER_GRP),
      .DATA_W  (DATA_W),
      .WA_W    (WADDR_W)
   ) u_regif (
      .clk      (clk),
      .rst_n    (rst_n),
      .waddr    (waddr),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .rd_en    (rd_en),
      .pend_all (pend_all),
      .mask_all (mask_all),
      .grp_req  (grp_req),
      .set_all  (set_all),
      .clr_all  (clr_all),
      .rd_data  (rd_data)
   );

   assign grp_irq = grp_req;

   assert_reset_clear_R11: assert property (@(posedge clk)
      $past(!rst_n) |-> (grp_irq == '0));
endmodule

// File: tb/irq_combiner_tb.sv
module irq_combiner_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [511:0] irq_in = '0;
   logic [6:0]   waddr = '0;
   logic         wr_en = 1'b0;
   logic [31:0]  wr_data = '0;
   logic         rd_en = 1'b0;
   logic [31:0]  rd_data, rd_data_s;
   logic [63:0]  grp_irq, grp_irq_s;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   irq_combiner u_dut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .waddr(waddr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data), .grp_irq(grp_irq));

   irq_combiner #(.REDUCED(1'b1)) u_dut_small (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .waddr(waddr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data_s), .grp_irq(grp_irq_s));

   task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input int wa, input logic [31:0] d);
      @(negedge clk);
      waddr = 7'(wa); wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input int wa, output logic [31:0] v, output logic [31:0] vs);
      @(negedge clk);
      waddr = 7'(wa); rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      v = rd_data; vs = rd_data_s;
   endtask

   task automatic drive_src(input int n, input logic lvl);
      @(negedge clk);
      irq_in[n] = lvl;
      @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v, vs;
      chk("R11 requests after reset", grp_irq, 64'h0);
      rd(64, v, vs); chk("R11 summary low", 64'(v), 64'h0);
      rd(65, v, vs); chk("R11 summary high", 64'(v), 64'h0);
      rd(3, v, vs);  chk("R11 masked status", 64'(v), 64'h0);
   endtask

   task automatic t_map_and_mask();
      logic [31:0] v, vs;
      // group 5 = quad 1 lane 1; enable bit 3
      wr(4, 32'h0000_0800);
      @(negedge clk);
      irq_in[5*8+2] = 1'b1;
      @(negedge clk);
      chk("R2 disabled source gives no request", grp_irq, 64'h0);
      drive_src(5*8+3, 1'b1);
      chk("R1 R2 enabled source raises group 5", grp_irq, 64'h20);
      rd(6, v, vs); chk("R3 R4 raw status quad1", 64'(v), 64'h0000_0C00);
      rd(7, v, vs); chk("R7 masked status quad1", 64'(v), 64'h0000_0800);
      rd(64, v, vs); chk("R8 summary word0", 64'(v), 64'h20);
   endtask

   task automatic t_upper_group();
      logic [31:0] v, vs;
      wr(40, 32'h0000_0001);  // group 40 = quad 10 lane 0, bit 0
      drive_src(320, 1'b1);
      chk("R1 group 40 request", grp_irq, 64'h0000_0100_0000_0020);
      rd(65, v, vs); chk("R8 summary word1", 64'(v), 64'h100);
   endtask

   task automatic t_set_zero_keeps();
      logic [31:0] v, vs;
      wr(4, 32'h0000_0400);
      wr(4, 32'h0000_0000);
      rd(7, v, vs); chk("R5 zeros leave mask set", 64'(v), 64'h0000_0C00);
   endtask

   task automatic t_illegal();
      logic [31:0] v, vs;
      wr(6, 32'hFFFF_FFFF);
      wr(7, 32'h0000_0000);
      wr(64, 32'h0);
      wr(65, 32'hFFFF_FFFF);
      wr(100, 32'hFFFF_FFFF);
      rd(7, v, vs); chk("R9 status writes ignored", 64'(v), 64'h0000_0C00);
      chk("R9 requests unchanged", grp_irq, 64'h0000_0100_0000_0020);
      rd(4, v, vs); chk("R9 enable-set reads zero", 64'(v), 64'h0);
      rd(5, v, vs); chk("R9 enable-clear reads zero", 64'(v), 64'h0);
      rd(66, v, vs); chk("R9 offset 0x108 reads zero", 64'(v), 64'h0);
   endtask

   task automatic t_clear();
      logic [31:0] v, vs;
      wr(5, 32'h0000_0C00);
      chk("R6 clear drops group 5", grp_irq, 64'h0000_0100_0000_0000);
      rd(7, v, vs); chk("R6 masked status after clear", 64'(v), 64'h0);
      wr(41, 32'h0000_0000);
      chk("R6 zeros leave group 40 enabled", grp_irq, 64'h0000_0100_0000_0000);
   endtask

   task automatic t_level_follow();
      logic [31:0] v, vs;
      drive_src(320, 1'b0);
      chk("R2 R3 request follows level low", grp_irq, 64'h0);
      rd(42, v, vs); chk("R3 raw status quad10 cleared", 64'(v), 64'h0);
   endtask

   task automatic t_rd_hold();
      logic [31:0] v, vs;
      rd(6, v, vs);
      @(negedge clk);
      irq_in[5*8+2] = 1'b0;
      repeat (3) @(negedge clk);
      chk("R12 read data held without strobe", 64'(rd_data), 64'(v));
      rd(6, v, vs); chk("R12 fresh read", 64'(v), 64'h0000_0800);
   endtask

   task automatic t_reduced();
      logic [31:0] v, vs;
      wr(20, 32'h0000_0001);  // group 20 bit 0
      wr(0,  32'h0100_0000);  // group 3 bit 0
      @(negedge clk);
      irq_in[160] = 1'b1;
      irq_in[24]  = 1'b1;
      @(negedge clk);
      chk("R10 reduced variant only group 3", grp_irq_s, 64'h8);
      rd(22, v, vs); chk("R10 reduced raw status upper quad", 64'(vs), 64'h0);
      chk("R10 full variant sees group 20", grp_irq, 64'h0010_0008 | 64'h0000_0000_0000_0000);
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: got hang expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_map_and_mask();
      t_upper_group();
      t_set_zero_keeps();
      t_illegal();
      t_clear();
      t_level_follow();
      t_rd_hold();
      t_reduced();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule